// File: doc/BRIEF.md
# Sampled Line Debouncer with Bounce Watchdog

This block cleans up one noisy binary line. The raw level first crosses a two-flop synchroniser. After that, the line is looked at only on cycles where a periodic sample strobe is high, so every time limit is a count of samples and not of clock cycles. A stability filter passes a new level to the output only when that level has been seen on a parameterised number of back-to-back samples. Shorter excursions never reach the output. The filter gives a one-cycle pulse on each cycle in which the filtered level really changes.

A second part runs at the same time as the filter. It times how long the line has stayed unsettled. The timer starts on the first sample that disagrees with the filtered level. It stops and clears as soon as the filter reports a settled run of samples, at either level. If the unsettled time goes past a parameterised sample limit, the watchdog sets a sticky fault. While the fault is set, the filtered level is frozen. Only an explicit clear or a reset removes the fault.

Top module: `sampled_debouncer`

## Requirements
- R1: During and after synchronous active-low reset, the filtered level is 0, the change pulse is 0 and the fault is 0. The filter treats the line as already settled at 0.
- R2: The raw line crosses a two-flop synchroniser. It is only examined on clock edges where the sample strobe is 1. The filtered level never changes on an edge where the strobe is 0, and a raw excursion that no strobe catches has no effect.
- R3: The filtered level takes a new value only after FILT_SAMPLES consecutive samples (default 3) have all shown that value. A run of fewer equal samples leaves the level unchanged.
- R4: The change pulse is high for exactly the one clock cycle that follows each edge on which the filtered level changes, and is low at all other times.
- R5: The bounce timer starts at the first sample that differs from the filtered level. It counts every later sample until a sample completes a run of FILT_SAMPLES equal values, which clears it. On a sample where BOUNCE_MAX (default 5) unsettled samples have already been counted, the fault is set. A line that settles within BOUNCE_MAX unsettled samples raises no fault.
- R6: Once set, the fault stays at 1 until the clear input is 1 on a clock edge. The clear takes priority over setting the fault in the same edge and also restarts the bounce timer.
- R7: While the fault is 1, the filtered level holds its value whatever the line does. After a clear, a line that has stayed settled at the other value is passed to the output on the next sample.
- R8: The run counter and the bounce timer saturate instead of wrapping. A line held for a long time, or bouncing for a long time, behaves the same as one held or bouncing just past the limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_en | input | 1 | Sample strobe, one cycle high per sample period |
| raw_in | input | 1 | Unsynchronised raw line |
| flt_clr | input | 1 | Clears the bounce fault and restarts the bounce timer |
| level_o | output | 1 | Debounced level |
| settle_pulse_o | output | 1 | One-cycle pulse when level_o changes |
| bounce_flt_o | output | 1 | Sticky bounce fault |

## Verification
The embedded properties watch these rules on every cycle: the level never moves without a strobe, the pulse and a level change always come together, the level is frozen under a fault, the fault is sticky and yields to the clear, and the timer is empty after a settled sample. Other behaviour depends on the length of sample sequences, and only the bench scenarios can show it: glitches that are filtered out, excursions between strobes that are ignored, a bounce pattern that settles exactly at the limit compared with one a sample longer, and a level passed through after a clear once a long run has saturated the counters. Those scenarios are compared every clock against a behavioural model.

// File: rtl/sdb_pkg.sv
// Shared types for the sampled debouncer.
package sdb_pkg;
    // Bounce watchdog phase: idle, or timing an unsettled stretch.
    typedef enum logic {
        WD_QUIET  = 1'b0,
        WD_TIMING = 1'b1
    } wd_state_e;
endpackage

// File: rtl/sdb_sync.sv
// Multi-flop synchroniser for one asynchronous line.
// Assumes STAGES >= 2; the reset value of every stage is 0.
module sdb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) begin
                chain_q[k] <= chain_q[k-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdb_filter.sv
// Stability filter. It tracks the current run of equal samples and
// reports a settled sample once the run reaches FILT_SAMPLES. A settled
// value that differs from the output level is passed on unless the
// fault input is set.
// Assumes FILT_SAMPLES >= 2. samp_i is already synchronised.
module sdb_filter #(
    parameter int FILT_SAMPLES = 3,
    parameter int RC_W         = $clog2(FILT_SAMPLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic samp_i,
    input  logic fault_i,
    output logic level_o,
    output logic pulse_o,
    output logic settled_o
);
    localparam logic [RC_W-1:0] RUN_FULL = RC_W'(FILT_SAMPLES);
    localparam logic [RC_W-1:0] RUN_ONE  = RC_W'(1);

    logic            prev_q, nxt_prev;
    logic [RC_W-1:0] run_q, nxt_run;
    logic            level_q, pulse_q;

    // Next run state: restart on a new value, otherwise count up to full.
    always_comb begin
        if (samp_i != prev_q) begin
            nxt_prev = samp_i;
            nxt_run  = RUN_ONE;
        end else begin
            nxt_prev = prev_q;
            nxt_run  = (run_q < RUN_FULL) ? run_q + RUN_ONE : run_q;
        end
    end

    // A sample is settled when it completes or extends a full run.
    assign settled_o = smp_en && (nxt_run == RUN_FULL);

    // Run tracking, level update and the change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            run_q   <= RUN_FULL;
            level_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (smp_en) begin
                prev_q <= nxt_prev;
                run_q  <= nxt_run;
                if ((nxt_run == RUN_FULL) && (nxt_prev != level_q) && !fault_i) begin
                    level_q <= nxt_prev;
                    pulse_q <= 1'b1;
                end
            end
        end
    end

    assign level_o = level_q;
    assign pulse_o = pulse_q;

    // The level moves only on a strobe edge.
    assert_strobe_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> $stable(level_q));

    // A level change and the pulse always come together.
    assert_pulse_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> pulse_q);
    assert_change_on_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (level_q != $past(level_q)));

    // The level is frozen while the fault is set.
    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> $stable(level_q));
endmodule

// File: rtl/sdb_bounce_wd.sv
// Bounce watchdog. It starts timing at the first sample that disagrees
// with the filtered level and stops on a settled sample. When more than
// BOUNCE_MAX unsettled samples are seen, it sets a sticky fault that
// only the clear input (or reset) removes.
// Assumes level_i is the filter's registered level and settled_i is
// valid only in strobe cycles.
module sdb_bounce_wd
    import sdb_pkg::*;
#(
    parameter int BOUNCE_MAX = 5,
    parameter int BT_W       = $clog2(BOUNCE_MAX + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic samp_i,
    input  logic level_i,
    input  logic settled_i,
    input  logic clr_i,
    output logic fault_o
);
    localparam logic [BT_W-1:0] LIMIT = BT_W'(BOUNCE_MAX);

    wd_state_e       state_q;
    logic [BT_W-1:0] timer_q;
    logic            fault_q;
    logic            differs;

    // The sampled line disagrees with the filtered level.
    assign differs = samp_i != level_i;

    // Timer phase, saturating count and sticky fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_QUIET;
            timer_q <= '0;
            fault_q <= 1'b0;
        end else if (clr_i) begin
            state_q <= WD_QUIET;
            timer_q <= '0;
            fault_q <= 1'b0;
        end else if (smp_en) begin
            if (settled_i) begin
                state_q <= WD_QUIET;
                timer_q <= '0;
            end else if ((state_q == WD_TIMING) || differs) begin
                state_q <= WD_TIMING;
                if (timer_q >= LIMIT) begin
                    fault_q <= 1'b1;
                end
                if (timer_q <= LIMIT) begin
                    timer_q <= timer_q + BT_W'(1);
                end
            end
        end
    end

    assign fault_o = fault_q;

    // The fault only rises once the timer has reached the limit.
    assert_fault_after_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> ($past(timer_q) >= LIMIT));

    // A settled sample leaves the timer empty.
    assert_settle_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && settled_i) |=> (timer_q == '0));

    // The fault is sticky and yields to the clear.
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !clr_i) |=> fault_q);
    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !fault_q);
endmodule

// File: rtl/sampled_debouncer.sv
// Top of the sampled debouncer: synchroniser, stability filter and
// bounce watchdog. All timing is counted in strobe samples.
// Assumes smp_en is a one-cycle strobe with a period longer than the
// synchroniser depth, and FILT_SAMPLES >= 2.
module sampled_debouncer #(
    parameter int FILT_SAMPLES = 3,
    parameter int BOUNCE_MAX   = 5,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic raw_in,
    input  logic flt_clr,
    output logic level_o,
    output logic settle_pulse_o,
    output logic bounce_flt_o
);
    localparam int RC_W = $clog2(FILT_SAMPLES + 1);
    localparam int BT_W = $clog2(BOUNCE_MAX + 2);

    logic samp;
    logic settled;
    logic fault;
    logic level;

    sdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (samp)
    );

    sdb_filter #(.FILT_SAMPLES(FILT_SAMPLES), .RC_W(RC_W)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_en    (smp_en),
        .samp_i    (samp),
        .fault_i   (fault),
        .level_o   (level),
        .pulse_o   (settle_pulse_o),
        .settled_o (settled)
    );

    sdb_bounce_wd #(.BOUNCE_MAX(BOUNCE_MAX), .BT_W(BT_W)) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_en    (smp_en),
        .samp_i    (samp),
        .level_i   (level),
        .settled_i (settled),
        .clr_i     (flt_clr),
        .fault_o   (fault)
    );

    assign level_o      = level;
    assign bounce_flt_o = fault;
endmodule

// File: tb/test_sampled_debouncer.sv
// Bench: a behavioural reference model checked against the design on
// every clock, plus directed checks at the ends of the scenarios.
module test_sampled_debouncer;
    localparam int FILT = 3;
    localparam int MAXB = 5;
    localparam int PER  = 4;

    logic clk = 1'b0, rst_n = 1'b0, smp_en = 1'b0, raw_in = 1'b0, flt_clr = 1'b0;
    logic level_o, settle_pulse_o, bounce_flt_o;

    int n_chk = 0, n_fail = 0, n_pulse = 0;
    bit cmp_on = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    bit mq[$] = '{1'b0, 1'b0};
    int m_prev = 0, m_run = FILT, m_lvl = 0, m_tmr = 0, m_flt = 0, m_pls = 0;

    sampled_debouncer #(.FILT_SAMPLES(FILT), .BOUNCE_MAX(MAXB), .SYNC_STAGES(2)) i_sampled_debouncer (
        .clk            (clk),
        .rst_n          (rst_n),
        .smp_en         (smp_en),
        .raw_in         (raw_in),
        .flt_clr        (flt_clr),
        .level_o        (level_o),
        .settle_pulse_o (settle_pulse_o),
        .bounce_flt_o   (bounce_flt_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp_v, input string what);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp_v, $time);
        end
    endtask

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        int samp, old_lvl, old_flt, settled;
        if (!rst_n) begin
            mq = '{1'b0, 1'b0};
            m_prev = 0; m_run = FILT; m_lvl = 0; m_tmr = 0; m_flt = 0; m_pls = 0;
        end else begin
            samp = mq[1];
            mq = '{raw_in, mq[0]};
            m_pls = 0;
            old_lvl = m_lvl;
            old_flt = m_flt;
            settled = 0;
            if (smp_en) begin
                if (samp != m_prev) begin
                    m_prev = samp;
                    m_run = 1;
                end else if (m_run < FILT) begin
                    m_run++;
                end
                settled = (m_run == FILT);
                if (settled && m_prev != old_lvl && !old_flt) begin
                    m_lvl = m_prev;
                    m_pls = 1;
                end
            end
            if (flt_clr) begin
                m_flt = 0;
                m_tmr = 0;
            end else if (smp_en) begin
                if (settled) m_tmr = 0;
                else if (m_tmr != 0 || samp != old_lvl) begin
                    if (m_tmr >= MAXB) m_flt = 1;
                    if (m_tmr <= MAXB) m_tmr++;
                end
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk({"R3/", cur_req}, int'(level_o), m_lvl, "level");
            chk({"R4/", cur_req}, int'(settle_pulse_o), m_pls, "pulse");
            chk({"R5/", cur_req}, int'(bounce_flt_o), m_flt, "fault");
            if (settle_pulse_o) n_pulse++;
        end
    end

    // Hold the raw line at v for n sample periods (strobe at the end of each).
    task automatic samples(input logic v, input int n);
        for (int s = 0; s < n; s++) begin
            for (int c = 0; c < PER; c++) begin
                @(negedge clk); #1;
                raw_in = v;
                smp_en = (c == PER - 1);
            end
        end
        @(negedge clk); #1;
        smp_en = 1'b0;
    endtask

    // Raw excursion in the first cycle of each period only: no strobe sees it.
    task automatic blip_between(input logic base, input int n);
        for (int s = 0; s < n; s++) begin
            for (int c = 0; c < PER; c++) begin
                @(negedge clk); #1;
                raw_in = (c == 0) ? ~base : base;
                smp_en = (c == PER - 1);
            end
        end
        @(negedge clk); #1;
        smp_en = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); #1;
        flt_clr = 1'b1;
        @(negedge clk); #1;
        flt_clr = 1'b0;
    endtask

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        // R1: reset state
        chk("R1", int'(level_o), 0, "reset level");
        chk("R1", int'(settle_pulse_o), 0, "reset pulse");
        chk("R1", int'(bounce_flt_o), 0, "reset fault");
        #1 rst_n = 1'b1;
        samples(1'b0, 3);

        // R3: a run of two high samples is filtered out
        cur_req = "R3";
        samples(1'b1, 2);
        samples(1'b0, 3);
        chk("R3", int'(level_o), 0, "short run filtered");

        // R3/R4: clean rise passes after three samples with one pulse
        cur_req = "R4";
        p0 = n_pulse;
        samples(1'b1, 4);
        chk("R3", int'(level_o), 1, "clean rise");
        chk("R4", n_pulse - p0, 1, "one pulse per change");

        // R2: excursions between strobes are never seen
        cur_req = "R2";
        blip_between(1'b1, 6);
        chk("R2", int'(level_o), 1, "between-strobe blip ignored");
        chk("R2", int'(bounce_flt_o), 0, "blip no fault");

        // R5: exactly MAXB unsettled samples then settle: no fault (level 1)
        cur_req = "R5";
        samples(1'b0, 1); samples(1'b1, 2); samples(1'b0, 3);
        chk("R5", int'(bounce_flt_o), 0, "settle at limit");
        chk("R5", int'(level_o), 0, "settled low");

        // R5: one more unsettled sample raises the fault (level 0)
        samples(1'b1, 1); samples(1'b0, 1); samples(1'b1, 1); samples(1'b0, 1);
        samples(1'b1, 3);
        chk("R5", int'(bounce_flt_o), 1, "fault past limit");

        // R7/R6: level frozen and fault sticky under a long settled run
        cur_req = "R7";
        chk("R7", int'(level_o), 0, "frozen after fault");
        samples(1'b1, 8);
        chk("R7", int'(level_o), 0, "frozen while settled high");
        chk("R6", int'(bounce_flt_o), 1, "fault sticky");

        // R6/R8: clear, then saturated run passes on the next sample
        cur_req = "R8";
        pulse_clear();
        chk("R6", int'(bounce_flt_o), 0, "clear removes fault");
        samples(1'b1, 1);
        chk("R8", int'(level_o), 1, "update after clear with saturated run");

        // R8: long bounce saturates the timer; fault stays, clear during strobe wins
        cur_req = "R6";
        for (int i = 0; i < 12; i++) samples(i[0] ? 1'b1 : 1'b0, 1);
        chk("R8", int'(bounce_flt_o), 1, "fault after long bounce");
        @(negedge clk); #1;
        flt_clr = 1'b1; smp_en = 1'b1; raw_in = 1'b0;
        @(negedge clk); #1;
        flt_clr = 1'b0; smp_en = 1'b0;
        chk("R6", int'(bounce_flt_o), 0, "clear beats set");
        samples(1'b1, 4);
        chk("R6", int'(bounce_flt_o), 0, "no refault after clear");
        chk("R8", int'(level_o), 1, "level settled high");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog for a hung run.
    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual 0 expected 1 (run ended)");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule